// File: doc/BRIEF.md
# Mode-Steered Port Wakeup Controller

This block holds the per-pin configuration and the wakeup logic of one 8-bit input port of a small microcontroller. The CPU has only one write path into the port's control registers. It carries the value of the working register. A separate 4-bit mode register decides which control register that write reaches. Software first loads the mode and then issues the write.

Most registers take the working value as a plain store. The wakeup-pending and comparator registers are different. An access to them is an exchange: the written value is stored, and the previous contents come back on a return bus one cycle later. This exchange is the only way software can read them.

Each pin input passes through a synchronizer. An enabled pin that shows its selected edge sets its pending flag. Any enabled pending flag raises a wakeup/interrupt request. The comparator's analog part is outside the block, and its result arrives as a digital input.

Top module: `pwk_port_wakeup`

## Requirements
- R1: While reset is asserted and afterwards until written, the mode register holds 0Fh and every control register (direction, level, Schmitt, wakeup enable, wakeup edge, pending, comparator) holds all ones. So `outEn` is 00h, `levelTtl` and `schmittOff` are FFh, `wakeIrq` is 0, and `wOut` is 00h.
- R2: A `modeWrEn` pulse loads `modeIn` into the mode register. A `cfgWrEn` write reaches only the register picked by the mode held before that edge. Mode values 00h–07h and 0Eh select nothing, and a write under them changes no output.
- R3: Mode 0Fh writes the direction register, where a 1 bit means input. `outEn` is the bitwise inverse of that register and changes on the edge after the write.
- R4: Mode 0Dh writes `levelTtl`, where 1 means TTL and 0 means CMOS. Mode 0Ch writes `schmittOff`, where 1 disables the Schmitt trigger.
- R5: Mode 09h is an exchange with the pending register. On the write edge the pending register takes `wIn` (apart from R9), `wOut` takes the old pending value, and `wOutValid` is high for exactly that one following cycle.
- R6: Mode 0Ah writes the edge register, where 1 means rising and 0 means falling. A pin change driven before clock edge k is seen through a two-stage synchronizer. The pending bit becomes set at edge k+2, so the change shows on `wakeIrq` after edge k+2 and not before.
- R7: Mode 0Bh writes the wakeup-enable register, which is active low. A pending bit can become set by an edge only while its enable bit is 0.
- R8: `wakeIrq` is high exactly when some pending bit is 1 and its enable bit is 0.
- R9: If an edge hit and a pending exchange fall on the same clock edge, that pending bit ends up 1 whatever `wIn` holds.
- R10: Mode 08h is an exchange with the comparator register. Bits 7..1 take `wIn[7:1]`, and `wOut` returns the old contents with a `wOutValid` pulse. Writes never set bit 0. On every edge where bit 7 is 0, bit 0 samples `cmpResult`. While bit 7 is 1, bit 0 holds its value.
- R11: `cmpDrive` is high when both bit 7 and bit 6 of the comparator register are 0. `cmpPinOut` equals bit 0 of the comparator register.
- R12: A pending bit, once set, stays set until a mode-09h exchange overwrites it. Writes to other registers and changes of the enable bits do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeWrEn | input | 1 | Load `modeIn` into the mode register |
| modeIn | input | 4 | New mode value |
| cfgWrEn | input | 1 | Write the working value into the register picked by the mode |
| wIn | input | 8 | Working-register value |
| pinIn | input | 8 | Asynchronous pin levels |
| cmpResult | input | 1 | Digital comparator result (1 when input 2 is above input 1) |
| outEn | output | 8 | Per-pin output enable, inverse of the direction register |
| levelTtl | output | 8 | Per-pin input threshold select, 1 = TTL |
| schmittOff | output | 8 | Per-pin Schmitt disable, 1 = disabled |
| wakeIrq | output | 1 | Wakeup/interrupt request |
| wOut | output | 8 | Value returned by the last exchange |
| wOutValid | output | 1 | One-cycle pulse marking a new `wOut` |
| cmpDrive | output | 1 | Comparator enabled and routed to pin 0 |
| cmpPinOut | output | 1 | Comparator result bit driven toward pin 0 |

## Verification
A stale or wrong mode register shows on the edge after the next configuration write. That write lands in the wrong register and moves `outEn`, `levelTtl` or `schmittOff`. Pending and enable state is hidden until `wakeIrq` changes or an exchange returns it on `wOut` one cycle later. A pending bit that is dropped, set while disabled or set by the wrong edge is therefore caught at the next exchange, or within three cycles of a pin change through the request line. A comparator bit that goes stale appears on `cmpPinOut` in the cycle after `cmpResult` moves.

// File: rtl/pwk_pkg.sv
package pwk_pkg;

  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MODE_CMP     = 4'h8;
  localparam logic [MODE_W-1:0] MODE_PEND    = 4'h9;
  localparam logic [MODE_W-1:0] MODE_EDGE    = 4'hA;
  localparam logic [MODE_W-1:0] MODE_WKEN    = 4'hB;
  localparam logic [MODE_W-1:0] MODE_SCHMITT = 4'hC;
  localparam logic [MODE_W-1:0] MODE_LEVEL   = 4'hD;
  localparam logic [MODE_W-1:0] MODE_DIR     = 4'hF;
  localparam logic [MODE_W-1:0] MODE_RESET   = MODE_DIR;

  typedef struct packed {
    logic wrLevel;
    logic wrSchmitt;
    logic wrWakeEn;
    logic wrEdge;
    logic wrDir;
    logic xchPend;
    logic xchCmp;
  } regStrobes_t;

endpackage

// File: rtl/pwk_ctrl.sv
module pwk_ctrl
  import pwk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWrEn,
  input  logic [MODE_W-1:0] modeIn,
  input  logic              cfgWrEn,
  output regStrobes_t       strb
);

  logic [MODE_W-1:0] modeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_RESET;
    end else if (modeWrEn) begin
      modeQ <= modeIn;
    end
  end

  // The decode uses the mode held before this edge; a mode load in the same
  // cycle only affects later writes.
  always_comb begin
    strb = '0;
    if (cfgWrEn) begin
      unique case (modeQ)
        MODE_LEVEL:   strb.wrLevel   = 1'b1;
        MODE_SCHMITT: strb.wrSchmitt = 1'b1;
        MODE_WKEN:    strb.wrWakeEn  = 1'b1;
        MODE_EDGE:    strb.wrEdge    = 1'b1;
        MODE_DIR:     strb.wrDir     = 1'b1;
        MODE_PEND:    strb.xchPend   = 1'b1;
        MODE_CMP:     strb.xchCmp    = 1'b1;
        default:      strb           = '0;
      endcase
    end
  end

endmodule

// File: rtl/pwk_datapath.sv
module pwk_datapath
  import pwk_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobes_t      strb,
  input  logic [WIDTH-1:0] wIn,
  input  logic [WIDTH-1:0] pinIn,
  input  logic             cmpResult,
  output logic [WIDTH-1:0] outEn,
  output logic [WIDTH-1:0] levelTtl,
  output logic [WIDTH-1:0] schmittOff,
  output logic             wakeIrq,
  output logic [WIDTH-1:0] wOut,
  output logic             wOutValid,
  output logic             cmpDrive,
  output logic             cmpPinOut,
  output logic [WIDTH-1:0] pendState,
  output logic [WIDTH-1:0] cmpState,
  output logic [WIDTH-1:0] wakeEnNState
);

  localparam int CMP_EN_BIT    = WIDTH - 1;
  localparam int CMP_ROUTE_BIT = WIDTH - 2;

  logic [WIDTH-1:0] levelQ, schmittQ, wakeEnNQ, edgeQ, dirQ;
  logic [WIDTH-1:0] pendQ, cmpQ, wOutQ;
  logic             validQ;
  logic [WIDTH-1:0] syncQ [SYNC_STAGES];
  logic [WIDTH-1:0] prevQ;
  logic [WIDTH-1:0] syncLast;
  logic [WIDTH-1:0] edgeHit;

  // Plain configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ   <= '1;
      schmittQ <= '1;
      wakeEnNQ <= '1;
      edgeQ    <= '1;
      dirQ     <= '1;
    end else begin
      if (strb.wrLevel)   levelQ   <= wIn;
      if (strb.wrSchmitt) schmittQ <= wIn;
      if (strb.wrWakeEn)  wakeEnNQ <= wIn;
      if (strb.wrEdge)    edgeQ    <= wIn;
      if (strb.wrDir)     dirQ     <= wIn;
    end
  end

  // Input synchronizer chain
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '0;
        else       syncQ[s] <= pinIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '0;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
  end

  assign syncLast = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= syncLast;
  end

  // Per-pin edge qualification
  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    logic riseSeen, fallSeen;
    assign riseSeen   = syncLast[p] & ~prevQ[p];
    assign fallSeen   = ~syncLast[p] & prevQ[p];
    assign edgeHit[p] = ~wakeEnNQ[p] & (edgeQ[p] ? riseSeen : fallSeen);
  end

  // Pending flags: an exchange overwrites them, a hit in the same cycle wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '1;
    else       pendQ <= (strb.xchPend ? wIn : pendQ) | edgeHit;
  end

  // Comparator register: upper bits by exchange, bit 0 tracks the result
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpQ <= '1;
    end else begin
      if (strb.xchCmp)    cmpQ[WIDTH-1:1] <= wIn[WIDTH-1:1];
      if (!cmpQ[CMP_EN_BIT]) cmpQ[0]      <= cmpResult;
    end
  end

  // Exchange return path
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wOutQ  <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= strb.xchPend | strb.xchCmp;
      if (strb.xchPend)     wOutQ <= pendQ;
      else if (strb.xchCmp) wOutQ <= cmpQ;
    end
  end

  assign outEn        = ~dirQ;
  assign levelTtl     = levelQ;
  assign schmittOff   = schmittQ;
  assign wakeIrq      = |(pendQ & ~wakeEnNQ);
  assign wOut         = wOutQ;
  assign wOutValid    = validQ;
  assign cmpDrive     = ~cmpQ[CMP_EN_BIT] & ~cmpQ[CMP_ROUTE_BIT];
  assign cmpPinOut    = cmpQ[0];
  assign pendState    = pendQ;
  assign cmpState     = cmpQ;
  assign wakeEnNState = wakeEnNQ;

endmodule

// File: rtl/pwk_port_wakeup.sv
module pwk_port_wakeup
  import pwk_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWrEn,
  input  logic [MODE_W-1:0] modeIn,
  input  logic              cfgWrEn,
  input  logic [WIDTH-1:0]  wIn,
  input  logic [WIDTH-1:0]  pinIn,
  input  logic              cmpResult,
  output logic [WIDTH-1:0]  outEn,
  output logic [WIDTH-1:0]  levelTtl,
  output logic [WIDTH-1:0]  schmittOff,
  output logic              wakeIrq,
  output logic [WIDTH-1:0]  wOut,
  output logic              wOutValid,
  output logic              cmpDrive,
  output logic              cmpPinOut
);

  regStrobes_t      strb;
  logic [WIDTH-1:0] pendState, cmpState, wakeEnNState;

  pwk_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeWrEn (modeWrEn),
    .modeIn   (modeIn),
    .cfgWrEn  (cfgWrEn),
    .strb     (strb)
  );

  pwk_datapath #(
    .WIDTH       (WIDTH),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .wIn          (wIn),
    .pinIn        (pinIn),
    .cmpResult    (cmpResult),
    .outEn        (outEn),
    .levelTtl     (levelTtl),
    .schmittOff   (schmittOff),
    .wakeIrq      (wakeIrq),
    .wOut         (wOut),
    .wOutValid    (wOutValid),
    .cmpDrive     (cmpDrive),
    .cmpPinOut    (cmpPinOut),
    .pendState    (pendState),
    .cmpState     (cmpState),
    .wakeEnNState (wakeEnNState)
  );

endmodule

// File: rtl/pwk_checker.sv
module pwk_checker
  import pwk_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input regStrobes_t      strb,
  input logic             cfgWrEn,
  input logic [WIDTH-1:0] wIn,
  input logic [WIDTH-1:0] pendState,
  input logic [WIDTH-1:0] cmpState,
  input logic [WIDTH-1:0] wakeEnNState,
  input logic [WIDTH-1:0] wOut,
  input logic             wOutValid,
  input logic [WIDTH-1:0] outEn,
  input logic [WIDTH-1:0] levelTtl,
  input logic [WIDTH-1:0] schmittOff
);

  assert_quiet_without_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> ($stable(outEn) && $stable(levelTtl) && $stable(schmittOff)));

  assert_dir_to_enable_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrDir |=> (outEn == ~$past(wIn)));

  assert_pend_return_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.xchPend |=> (wOutValid && wOut == $past(pendState)));

  assert_gated_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.xchPend |=> ((pendState & ~$past(pendState) & $past(wakeEnNState)) == '0));

  assert_cmp_return_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.xchCmp |=> (wOutValid && wOut == $past(cmpState)));

  assert_pend_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    !strb.xchPend |=> ((pendState & $past(pendState)) == $past(pendState)));

endmodule

bind pwk_port_wakeup pwk_checker #(.WIDTH(WIDTH)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .strb         (strb),
  .cfgWrEn      (cfgWrEn),
  .wIn          (wIn),
  .pendState    (pendState),
  .cmpState     (cmpState),
  .wakeEnNState (wakeEnNState),
  .wOut         (wOut),
  .wOutValid    (wOutValid),
  .outEn        (outEn),
  .levelTtl     (levelTtl),
  .schmittOff   (schmittOff)
);

// File: tb/pwk_port_wakeup_test.sv
module pwk_port_wakeup_test;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int RAND_CYCLES = 3000;
  localparam int WATCHDOG    = 100000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         modeWrEn = 1'b0;
  logic [3:0]   modeIn = 4'h0;
  logic         cfgWrEn = 1'b0;
  logic [W-1:0] wIn = '0;
  logic [W-1:0] pinIn = '0;
  logic         cmpResult = 1'b0;
  logic [W-1:0] outEn, levelTtl, schmittOff, wOut;
  logic         wakeIrq, wOutValid, cmpDrive, cmpPinOut;

  int checks = 0;
  int fails  = 0;
  int cycleCount = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwk_port_wakeup #(.WIDTH(W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeIn(modeIn),
    .cfgWrEn(cfgWrEn), .wIn(wIn), .pinIn(pinIn), .cmpResult(cmpResult),
    .outEn(outEn), .levelTtl(levelTtl), .schmittOff(schmittOff),
    .wakeIrq(wakeIrq), .wOut(wOut), .wOutValid(wOutValid),
    .cmpDrive(cmpDrive), .cmpPinOut(cmpPinOut)
  );

  // Reference state, built from the requirements
  logic [3:0]   mMode;
  logic [W-1:0] mLevel, mSch, mEn, mEdge, mDir, mPend, mCmp, mWOut;
  logic [W-1:0] mS1, mS2, mPrev;
  logic         mValid;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = 4'hF; mLevel = '1; mSch = '1; mEn = '1; mEdge = '1; mDir = '1;
      mPend = '1; mCmp = '1; mWOut = '0; mValid = 1'b0;
      mS1 = '0; mS2 = '0; mPrev = '0;
    end else begin
      logic [W-1:0] hits, nPend, nCmp;
      hits  = ~mEn & ((mEdge & mS2 & ~mPrev) | (~mEdge & ~mS2 & mPrev));
      nPend = mPend;
      nCmp  = mCmp;
      mValid = 1'b0;
      if (cfgWrEn) begin
        case (mMode)
          4'hD: mLevel = wIn;
          4'hC: mSch   = wIn;
          4'hB: mEn    = wIn;
          4'hA: mEdge  = wIn;
          4'hF: mDir   = wIn;
          4'h9: begin mWOut = mPend; nPend = wIn; mValid = 1'b1; end
          4'h8: begin mWOut = mCmp; nCmp[W-1:1] = wIn[W-1:1]; mValid = 1'b1; end
          default: ;
        endcase
      end
      if (!mCmp[W-1]) nCmp[0] = cmpResult;
      mPend = nPend | hits;
      mCmp  = nCmp;
      mPrev = mS2; mS2 = mS1; mS1 = pinIn;
      if (modeWrEn) mMode = modeIn;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycleCount);
    end
  endtask

  task automatic compareAll();
    logic [W-1:0] expIrqVec;
    expIrqVec = mPend & ~mEn;
    check(outEn == ~mDir, "R3 outEn", 32'(outEn), 32'(~mDir));
    check(levelTtl == mLevel, "R4 levelTtl", 32'(levelTtl), 32'(mLevel));
    check(schmittOff == mSch, "R4 schmittOff", 32'(schmittOff), 32'(mSch));
    check(wakeIrq == (|expIrqVec), "R8 wakeIrq", 32'(wakeIrq), 32'(|expIrqVec));
    check(wOut == mWOut, "R5/R10 wOut", 32'(wOut), 32'(mWOut));
    check(wOutValid == mValid, "R5 wOutValid", 32'(wOutValid), 32'(mValid));
    check(cmpDrive == (~mCmp[W-1] & ~mCmp[W-2]), "R11 cmpDrive", 32'(cmpDrive), 32'(~mCmp[W-1] & ~mCmp[W-2]));
    check(cmpPinOut == mCmp[0], "R11 cmpPinOut", 32'(cmpPinOut), 32'(mCmp[0]));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic setMode(input logic [3:0] m);
    modeWrEn = 1'b1; modeIn = m;
    tick();
    modeWrEn = 1'b0;
  endtask

  task automatic writeW(input logic [W-1:0] v);
    cfgWrEn = 1'b1; wIn = v;
    tick();
    cfgWrEn = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > WATCHDOG) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycleCount, WATCHDOG);
      finish();
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1: reset values
    check(outEn == 8'h00, "R1 outEn", 32'(outEn), 32'h00);
    check(levelTtl == 8'hFF, "R1 levelTtl", 32'(levelTtl), 32'hFF);
    check(schmittOff == 8'hFF, "R1 schmittOff", 32'(schmittOff), 32'hFF);
    check(wakeIrq == 1'b0, "R1 wakeIrq", 32'(wakeIrq), 32'h0);
    check(wOut == 8'h00, "R1 wOut", 32'(wOut), 32'h00);
    rstN = 1'b1;
    tick();

    // R2: write under unused mode 0Eh touches nothing
    setMode(4'hE);
    writeW(8'h00);
    check(outEn == 8'h00 && levelTtl == 8'hFF && schmittOff == 8'hFF, "R2 ignored write",
          32'({outEn, levelTtl}), 32'h00FF);
    // R3: direction write
    setMode(4'hF);
    writeW(8'h5A);
    check(outEn == 8'hA5, "R3 direction", 32'(outEn), 32'hA5);

    // R5: clear pending from reset, old contents returned
    setMode(4'h9);
    writeW(8'h00);
    check(wOut == 8'hFF && wOutValid, "R5 exchange return", 32'(wOut), 32'hFF);
    tick();
    check(!wOutValid, "R5 single pulse", 32'(wOutValid), 32'h0);

    // R6/R7: enable pin0 only, rising edges; raise pins 0 and 1
    setMode(4'hB);
    writeW(8'hFE);
    setMode(4'hA);
    writeW(8'h03);
    pinIn = 8'h03;
    tick();
    tick();
    check(wakeIrq == 1'b0, "R6 no early request", 32'(wakeIrq), 32'h0);
    tick();
    check(wakeIrq == 1'b1, "R6 request after sync", 32'(wakeIrq), 32'h1);
    // R12: other writes do not clear
    writeW(8'h03);
    setMode(4'hB);
    writeW(8'hFF);
    writeW(8'hFE);
    check(wakeIrq == 1'b1, "R12 pending kept", 32'(wakeIrq), 32'h1);
    setMode(4'h9);
    writeW(8'h00);
    check(wOut == 8'h01, "R7 disabled pin not pending", 32'(wOut), 32'h01);

    // R9: hit coincides with exchange
    pinIn = 8'h00;
    repeat (4) tick();
    pinIn = 8'h01;
    tick();
    tick();
    writeW(8'h00);
    check(wOut == 8'h00, "R9 prior value", 32'(wOut), 32'h00);
    writeW(8'h00);
    check(wOut == 8'h01, "R9 edge wins", 32'(wOut), 32'h01);

    // R10/R11: comparator enable and route
    cmpResult = 1'b1;
    setMode(4'h8);
    writeW(8'h3E);
    check(wOut == 8'hFF, "R10 cmp return", 32'(wOut), 32'hFF);
    tick();
    check(cmpDrive && cmpPinOut, "R11 routed result", 32'({cmpDrive, cmpPinOut}), 32'h3);
    cmpResult = 1'b0;
    tick();
    check(cmpPinOut == 1'b0, "R10 tracks result", 32'(cmpPinOut), 32'h0);

    // Random phase
    for (int i = 0; i < RAND_CYCLES; i++) begin
      modeWrEn  = ($urandom % 4) == 0;
      modeIn    = 4'($urandom);
      cfgWrEn   = ($urandom % 2) == 0;
      wIn       = W'($urandom);
      cmpResult = 1'($urandom);
      if (($urandom % 3) == 0) pinIn = pinIn ^ W'($urandom);
      tick();
    end
    finish();
  end

endmodule